// File: doc/BRIEF.md
# Watchdog Timer with Selectable Prescaler

This block watches for a program that has stopped servicing it. A down-counter with all ones as its starting value steps once per prescaler tick. The prescaler is a free-running divider of the bus clock. Its ratio depends on which clock source feeds the bus and on a control bit. Software restarts the count by writing to a start register. If the count passes below zero first, the block raises an underflow event.

The kind of event is set by a sticky mode bit. In interrupt mode the block emits a one-cycle interrupt request, reloads the counter and keeps running. In reset mode it emits a one-cycle reset request and halts with the count at zero. Software can set the mode bit but cannot clear it; only system reset returns it to interrupt mode.

After system reset the counter and the prescaler stay idle until the first start write. A freeze input holds both while the system is in a low-power or bus-hold state. The current count and the mode bit are visible on status outputs.

Top module: `wdog_timer`

## Requirements
- R1: After reset, count_o is all ones, reset_mode_o is 0, and neither request is asserted. The count does not move until a start write is accepted.
- R2: A write of any data to START_ADDR (default 2) loads all ones into the counter and enables counting. The new value shows on count_o in the cycle after the write.
- R3: With sub_clk_i at 0, bit 0 of the register at CTRL_ADDR (default 1) selects the tick ratio: 0 gives one tick per 16 bus cycles and 1 gives one tick per 128. A full period from start to underflow is therefore 2^CNT_W ticks.
- R4: With sub_clk_i at 1, one tick occurs every 2 bus cycles, whatever bit 0 of the control register holds.
- R5: In interrupt mode, underflow asserts irq_o for exactly one cycle. In that same cycle count_o shows all ones again, and the next period has the same length.
- R6: Writing data with bit 0 set to MODE_ADDR (default 0) sets reset_mode_o. Writes with bit 0 clear have no effect. Only system reset clears the bit.
- R7: In reset mode, underflow asserts rst_req_o for exactly one cycle and never asserts irq_o. The counter then stays at zero until the next start write.
- R8: A start write does not clear the prescaler. The first tick after a restart comes when the prescaler completes its current cycle.
- R9: While freeze_i is 1, the counter and the prescaler hold their values. They resume from those values when freeze_i returns to 0.
- R10: A start write accepted in the same cycle as an underflow takes priority. No request is issued, and the counter loads all ones.
- R11: A change of ratio takes effect only when the prescaler next wraps.
- R12: irq_o and rst_req_o are never asserted together. Each cycle, count_o either holds, drops by one, or returns to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset |
| freeze_i | input | 1 | Holds counter and prescaler (stop, wait, hold) |
| sub_clk_i | input | 1 | 1 when the bus runs from the sub clock source |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| irq_o | output | 1 | One-cycle interrupt request on underflow |
| rst_req_o | output | 1 | One-cycle reset request on underflow |
| count_o | output | CNT_W | Current counter value |
| reset_mode_o | output | 1 | Sticky mode bit, 1 selects reset on underflow |

## Verification
The bound checker checks a set of properties on every cycle:
- that the two requests are exclusive and each lasts one cycle;
- the count on each request;
- that the mode bit never falls;
- that a start write reloads the count and suppresses any request;
- that freeze holds the count;
- that the count moves only by one step or a reload.

Other behaviours depend on long sequences, and only the bench scenarios can show them:
- the period lengths for each ratio and clock source;
- the idle state after reset;
- the prescaler phase kept across a restart;
- a ratio change applied only at the next wrap;
- exact recovery after a freeze.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int CNT_W    = 15,
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int DIV_SUB  = 2,
  parameter int DIV_FAST = 16,
  parameter int DIV_SLOW = 128,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 0,
  parameter logic [ADDR_W-1:0] CTRL_ADDR  = 1,
  parameter logic [ADDR_W-1:0] START_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze_i,
  input  logic              sub_clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o,
  output logic              rst_req_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              reset_mode_o
);

  localparam int DIV_MAX0 = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int DIV_MAX  = (DIV_MAX0 > DIV_SUB) ? DIV_MAX0 : DIV_SUB;
  localparam int PRE_W    = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [CNT_W-1:0] RELOAD = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q, term_q, term_sel;
  logic             slow_q, mode_q, run_q, irq_q, rrq_q;

  wire unused_data = ^wr_data_i[DATA_W-1:1];

  wire start_wr = wr_en_i && (wr_addr_i == START_ADDR);
  wire ctrl_wr  = wr_en_i && (wr_addr_i == CTRL_ADDR);
  wire mode_wr  = wr_en_i && (wr_addr_i == MODE_ADDR) && wr_data_i[0];

  assign term_sel = sub_clk_i ? PRE_W'(DIV_SUB - 1)
                  : slow_q    ? PRE_W'(DIV_SLOW - 1)
                  :             PRE_W'(DIV_FAST - 1);

  wire active = run_q && !freeze_i;
  wire wrap   = active && (pre_q == term_q);
  wire under  = wrap && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      pre_q  <= '0;
      term_q <= PRE_W'(DIV_FAST - 1);
      slow_q <= 1'b0;
      mode_q <= 1'b0;
      run_q  <= 1'b0;
      irq_q  <= 1'b0;
      rrq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      rrq_q <= 1'b0;
      if (ctrl_wr) slow_q <= wr_data_i[0];
      if (mode_wr) mode_q <= 1'b1;
      if (!run_q || wrap) term_q <= term_sel;
      if (active) pre_q <= wrap ? '0 : pre_q + 1'b1;
      if (start_wr) begin
        cnt_q <= RELOAD;
        run_q <= 1'b1;
      end else if (under) begin
        if (mode_q) begin
          rrq_q <= 1'b1;
          run_q <= 1'b0;
        end else begin
          irq_q <= 1'b1;
          cnt_q <= RELOAD;
        end
      end else if (wrap) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign irq_o        = irq_q;
  assign rst_req_o    = rrq_q;
  assign count_o      = cnt_q;
  assign reset_mode_o = mode_q;

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter int CNT_W  = 15,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] START_ADDR = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              freeze_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              reset_mode_o
);
  wire start_seen = wr_en_i && (wr_addr_i == START_ADDR);

  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && rst_req_o));
  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  a_r7_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
  a_r5_irq_reloaded: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (count_o == '1));
  a_r7_rst_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (count_o == '0));
  a_r6_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    reset_mode_o |=> reset_mode_o);
  a_r10_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (count_o == '1) && !irq_o && !rst_req_o);
  a_r9_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !start_seen) |=> $stable(count_o));
  a_r12_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count_o == $past(count_o)) || (count_o == CNT_W'($past(count_o) - 1'b1))
             || (count_o == '1));
endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .freeze_i(freeze_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .irq_o(irq_o), .rst_req_o(rst_req_o), .count_o(count_o), .reset_mode_o(reset_mode_o));

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int CW = 6, AW = 4, DW = 8;
  localparam int MAXV = (1 << CW) - 1;
  localparam logic [AW-1:0] A_MODE = 0, A_CTRL = 1, A_START = 2;
  // columns: sub clock select, control bit 0, expected ratio
  localparam int VEC [4][3] = '{'{0, 0, 16}, '{0, 1, 128}, '{1, 0, 2}, '{1, 1, 2}};

  logic clk = 0, rst_n = 0, freeze = 0, sub_clk = 0, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  wire irq, rrq, mode;
  wire [CW-1:0] count;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wdog_timer #(.CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .freeze_i(freeze), .sub_clk_i(sub_clk),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_o(irq), .rst_req_o(rrq), .count_o(count), .reset_mode_o(mode));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; freeze = 0; sub_clk = 0; wr_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic wait_evt(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq && !rrq && n < 20000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, pulses, c;
    do_reset();
    // R1 reset state and idle
    chk("R1 count", count, MAXV);
    chk("R1 mode", mode, 0);
    chk("R1 irq", irq, 0);
    pulses = 0;
    repeat (200) begin @(negedge clk); pulses += irq + rrq; end
    chk("R1 idle count", count, MAXV);
    chk("R1 idle pulses", pulses, 0);

    // R3 R4 R5 table
    for (int i = 0; i < 4; i++) begin
      do_reset();
      sub_clk = VEC[i][0];
      wr(A_CTRL, DW'(VEC[i][1]));
      repeat (2) @(negedge clk);
      wr(A_START, 8'hA5);
      wait_evt(n);
      chk(VEC[i][0] ? "R4 period" : "R3 period", n, (MAXV + 1) * VEC[i][2]);
      chk("R5 irq", irq, 1);
      chk("R5 reload", count, MAXV);
      wait_evt(n);
      chk("R5 second period", n, (MAXV + 1) * VEC[i][2]);
      @(negedge clk);
      chk("R5 one cycle", irq, 0);
    end

    // R6 mode latch
    do_reset();
    wr(A_MODE, 8'hFE);
    chk("R6 zero ignored", mode, 0);
    wr(A_MODE, 8'h01);
    chk("R6 set", mode, 1);
    wr(A_MODE, 8'h00);
    wr(A_START, 8'h00);
    chk("R6 sticky", mode, 1);
    do_reset();
    chk("R6 reset clears", mode, 0);

    // R7 reset mode
    do_reset();
    sub_clk = 1;
    wr(A_MODE, 8'h01);
    wr(A_START, 8'h00);
    wait_evt(n);
    chk("R7 period", n, (MAXV + 1) * 2);
    chk("R7 rst_req", rrq, 1);
    chk("R7 no irq", irq, 0);
    chk("R7 count zero", count, 0);
    pulses = 0;
    repeat (100) begin @(negedge clk); pulses += irq + rrq; end
    chk("R7 halted pulses", pulses, 0);
    chk("R7 halted count", count, 0);

    // R8 prescaler phase kept across restart (ratio 16)
    do_reset();
    wr(A_START, 8'h00);
    repeat (10) @(negedge clk);
    wr(A_START, 8'h00);
    chk("R2 restart reload", count, MAXV);
    wait_evt(n);
    chk("R8 restart period", n, (16 - 11) + MAXV * 16);

    // R9 freeze
    do_reset();
    sub_clk = 1;
    wr(A_START, 8'h00);
    repeat (20) @(negedge clk);
    freeze = 1;
    @(negedge clk);
    c = count;
    repeat (39) @(negedge clk);
    chk("R9 held count", count, c);
    freeze = 0;
    wait_evt(n);
    chk("R9 resumed period", 20 + 40 + n, (MAXV + 1) * 2 + 40);

    // R10 start coincides with underflow
    do_reset();
    sub_clk = 1;
    wr(A_START, 8'h00);
    repeat ((MAXV + 1) * 2 - 1) @(negedge clk);
    wr(A_START, 8'h00);
    chk("R10 no irq", irq, 0);
    chk("R10 reload", count, MAXV);
    wait_evt(n);
    chk("R10 next period", n, (MAXV + 1) * 2);

    // R11 ratio change applies at next wrap
    do_reset();
    wr(A_CTRL, 8'h00);
    repeat (2) @(negedge clk);
    wr(A_START, 8'h00);
    repeat (4) @(negedge clk);
    wr(A_CTRL, 8'h01);
    wait_evt(n);
    chk("R11 mixed period", 5 + n, 16 + MAXV * 128);
    chk("R12 exclusive", irq + rrq, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule